// File: doc/BRIEF.md
# Partially Segmented DAC Cell Encoder

This block converts a binary sample code into the cell-enable pattern for a current-steering array that is only partly segmented. The low field of the code, a parameterised number of bits, maps straight onto binary-weighted cells: bit k of that field switches a cell worth 2^k units. The high field becomes a thermometer code. Each thermometer bit switches one identical unit cell worth 2^LO_BITS units, and the number of ones in the code equals the value of the high field.

Every enable leaves the block through its own flop. All of these flops share the sample clock, so every cell changes state on the same edge. A synchronous reset clears all enables, which gives zero output current.

Top module: `seg_dac_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `lsb_en` and `msb_en` is 0 after that edge.
- R2: `lsb_en` equals bits [LO_BITS-1:0] of the `code` value sampled at the previous rising edge (default LO_BITS=4).
- R3: `msb_en` has 2^HI_BITS-1 bits, with HI_BITS = CODE_W-LO_BITS (default CODE_W=8, so 15 bits). The number of ones in it equals the value of `code[CODE_W-1:LO_BITS]` sampled at the previous edge.
- R4: The ones of `msb_en` are packed from bit 0 upward with no gaps: bit i is 1 exactly when i is less than the high-field value.
- R5: Outputs change exactly one clock cycle after `code` is sampled. Between edges they hold their values.
- R6: For every code, `lsb_en` + 2^LO_BITS * countones(`msb_en`) equals the code.
- R7: When the high field grows by one across a major carry (for example high field 0111 to 1000), exactly one `msb_en` bit turns from 0 to 1 and none turns from 1 to 0.
- R8: Over a full ascending sweep of the codes, the count of ones in `msb_en` never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| code | input | CODE_W | Binary sample code |
| lsb_en | output | LO_BITS | Registered enables for the binary-weighted cells |
| msb_en | output | 2^HI_BITS-1 | Registered thermometer enables for the unit cells |

## Verification
Every code is first applied in ascending order. This exposes any break in the weighted-sum identity and any drop in the thermometer count. Paired codes straddle each major carry, so a design that turns a cell off there, or turns on more than one, is told apart from a correct one. Random codes then arrive back to back, and they separate a design with the wrong latency from one that holds stale outputs. A reset applied in the middle of the stream confirms that the enables clear.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  // Thermometer pattern with the low `val` bits set.
  function automatic logic [255:0] therm_fill(input int unsigned val, input int unsigned width);
    logic [255:0] t;
    t = '0;
    for (int i = 0; i < 256; i++) begin
      if (i < width && i < val) t[i] = 1'b1;
    end
    return t;
  endfunction
endpackage

// File: rtl/seg_therm_dec.sv
module seg_therm_dec #(
  parameter int IN_W  = 4,
  localparam int OUT_W = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  bin,
  output logic [OUT_W-1:0] therm
);
  // Each output compares its own index against the code.
  for (genvar i = 0; i < OUT_W; i++) begin : g_cmp
    assign therm[i] = (32'(bin) > i);
  end
endmodule

// File: rtl/seg_en_reg.sv
module seg_en_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/seg_dac_encoder.sv
module seg_dac_encoder #(
  parameter int CODE_W  = 8,
  parameter int LO_BITS = 4,
  localparam int HI_BITS = CODE_W - LO_BITS,
  localparam int THERM_W = (1 << HI_BITS) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CODE_W-1:0]  code,
  output logic [LO_BITS-1:0] lsb_en,
  output logic [THERM_W-1:0] msb_en
);
  logic [LO_BITS-1:0] lo_field;
  logic [HI_BITS-1:0] hi_field;
  logic [THERM_W-1:0] therm_next;

  assign lo_field = code[LO_BITS-1:0];
  assign hi_field = code[CODE_W-1:LO_BITS];

  seg_therm_dec #(.IN_W(HI_BITS)) u_dec (.bin(hi_field), .therm(therm_next));

  seg_en_reg #(.W(LO_BITS)) u_lsb_reg (.clk(clk), .rst(rst), .d(lo_field),   .q(lsb_en));
  seg_en_reg #(.W(THERM_W)) u_msb_reg (.clk(clk), .rst(rst), .d(therm_next), .q(msb_en));

  // Named events for the checks below.
  logic [CODE_W-1:0] weighted_sum;
  logic              therm_packed;
  logic              started;
  assign weighted_sum = CODE_W'(lsb_en) + CODE_W'($countones(msb_en) << LO_BITS);
  assign therm_packed = ((msb_en & (msb_en + 1'b1)) == '0);

  always_ff @(posedge clk) begin
    if (rst) started <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (lsb_en == '0 && msb_en == '0));
  assert_lsb_pass_R2: assert property (@(posedge clk) disable iff (rst) started |=> lsb_en == $past(lo_field));
  assert_count_R3: assert property (@(posedge clk) disable iff (rst)
    started |=> $countones(msb_en) == int'($past(hi_field)));
  assert_packed_R4: assert property (@(posedge clk) disable iff (rst) started |-> therm_packed);
  assert_sum_R6: assert property (@(posedge clk) disable iff (rst) started |=> weighted_sum == $past(code));
  assert_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && $countones(msb_en) == $countones($past(msb_en)) + 1)
      |-> (($past(msb_en) & ~msb_en) == '0 && $countones(msb_en & ~$past(msb_en)) == 1));
endmodule

// File: tb/sim_seg_dac_encoder.sv
`timescale 1ns/1ps
module sim_seg_dac_encoder;
  localparam int CW = 8;
  localparam int LB = 4;
  localparam int HB = CW - LB;
  localparam int TW = (1 << HB) - 1;

  logic clk = 0;
  logic rst = 1;
  logic [CW-1:0] code = '0;
  logic [LB-1:0] lsb_en;
  logic [TW-1:0] msb_en;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seg_dac_encoder #(.CODE_W(CW), .LO_BITS(LB)) u0 (
    .clk(clk), .rst(rst), .code(code), .lsb_en(lsb_en), .msb_en(msb_en));

  function automatic logic [TW-1:0] exp_therm(input int v);
    logic [TW-1:0] t = '0;
    for (int i = 0; i < v; i++) t[i] = 1'b1;
    return t;
  endfunction

  function automatic int ones(input logic [TW-1:0] t);
    int n = 0;
    for (int i = 0; i < TW; i++) n += t[i];
    return n;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // Apply a code, wait one edge, then sample on the falling edge.
  task automatic apply(input int v);
    code = CW'(v);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic full_check(input int v);
    int hi = v >> LB;
    check("R2", int'(lsb_en), v & ((1 << LB) - 1));
    check("R3", ones(msb_en), hi);
    check("R4", int'(msb_en == exp_therm(hi)), 1);
    check("R6", int'(lsb_en) + (ones(msb_en) << LB), v);
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int prev_cnt;
    logic [TW-1:0] prev_t;
    void'($urandom(1234));
    code = 8'hFF;
    @(posedge clk); @(negedge clk);
    check("R1", int'(lsb_en), 0);
    check("R1", int'(msb_en), 0);
    rst = 0;

    // Ascending sweep: R6 identity and R8 monotonic count.
    prev_cnt = 0;
    for (int v = 0; v < (1 << CW); v++) begin
      apply(v);
      full_check(v);
      check("R8", int'(ones(msb_en) >= prev_cnt), 1);
      prev_cnt = ones(msb_en);
    end

    // Major carries: exactly one cell turns on, none turns off.
    for (int h = 0; h < (1 << HB) - 1; h++) begin
      apply((h << LB) | ((1 << LB) - 1));
      prev_t = msb_en;
      apply((h + 1) << LB);
      check("R7", ones(msb_en & ~prev_t), 1);
      check("R7", int'(prev_t & ~msb_en), 0);
    end

    // Latency and hold: change code mid-cycle, outputs stay until the edge.
    apply(8'h5A);
    code = 8'hC3;
    #1;
    check("R5", int'(lsb_en), 4'hA);
    check("R5", ones(msb_en), 5);
    @(posedge clk); @(negedge clk);
    check("R5", int'(lsb_en), 4'h3);
    check("R5", ones(msb_en), 12);

    // Random codes, back to back.
    for (int k = 0; k < 500; k++) begin
      int v = int'($urandom() % (1 << CW));
      apply(v);
      full_check(v);
    end

    // Reset in the middle of the stream.
    code = 8'hEE;
    rst = 1;
    @(posedge clk); @(negedge clk);
    check("R1", int'(lsb_en), 0);
    check("R1", int'(msb_en), 0);
    rst = 0;
    apply(8'hEE);
    full_check(8'hEE);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule